// File: doc/BRIEF.md
# Single-Round Integrity Tag Unit

This block produces a short 32-bit integrity tag for a 128-bit plaintext block by running one keyed cipher round over it and keeping a quarter of the result. The data is first mixed with an input key. It then goes through byte substitution, row rotation and column mixing, and a second key is added at the end. From each of the four 32-bit output columns one byte is kept. Because column mixing spreads every substituted byte over a whole column, a change to any input bit moves at least one tag byte. The tag is a truncated round output, not a checksum or a full hash.

On the write path the tag is computed from plaintext before it is enciphered and is then stored elsewhere. On the read path the deciphered block is fed back in check mode together with the stored tag, and the unit reports whether the recomputed tag agrees. A 256-bit line is covered by two independent 128-bit blocks, so the line carries two tags and 64 bits of check in total. Key expansion and tag storage sit outside this block; the substitution table is computed inside it.

Top module: `itu_tag_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are 0. From the second rising edge after `rst_n` goes high, `in_ready` is 1.
- R2: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` = 1 after the next rising edge and stays for exactly one cycle. Accepted blocks on consecutive edges give results on consecutive cycles.
- R3: Byte k of a 128-bit word is bits [127-8k -: 8], at row k mod 4 and column k div 4. The round does four things in order. It XORs `in_data` with `in_rkey0`. It applies the standard cipher substitution box (S(0x00)=0x63) to every byte. It moves the byte at row r, column c to column (c-r) mod 4. It multiplies each column by the standard mixing matrix over GF(2^8) with reduction polynomial 0x11B, then XORs the result with `in_rkey1`.
- R4: `out_tag[31-8c -: 8]` is the row-0 byte of output column c, for c = 0..3.
- R5: When the result came from a block accepted with `in_check` = 0 (generate), `out_match` and `out_fail` are both 0.
- R6: When the result came from a block accepted with `in_check` = 1, `out_match` is 1 exactly when `out_tag` equals the `in_ref_tag` captured at acceptance, and `out_fail` is its complement.
- R7: Input values on edges where `in_valid` is 0 are ignored: they produce no `out_valid` pulse and do not alter a result already in flight.
- R8: Flipping one bit of `in_data` with both keys fixed changes exactly one tag byte. If the bit sits in row r, column c, that byte is the one for column (c-r) mod 4.
- R9: `in_check` and `in_ref_tag` are taken together with the data at acceptance. Later changes do not affect that block's result.
- R10: With all-zero data and keys the tag is 0x63636363. With data 00112233445566778899aabbccddeeff, key 0 equal to 000102030405060708090a0b0c0d0e0f and key 1 equal to d6aa74fdd2af72fadaa678f1d6ab76fe, the tag is 0x89852dcb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | Unit accepts a block this cycle |
| in_data | input | 128 | Plaintext or deciphered block |
| in_rkey0 | input | 128 | Key added before the round |
| in_rkey1 | input | 128 | Key added at the end of the round |
| in_check | input | 1 | 0 = generate tag, 1 = check against reference |
| in_ref_tag | input | 32 | Stored tag for check mode |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | 32 | Computed tag |
| out_match | output | 1 | Check mode: tags agree |
| out_fail | output | 1 | Check mode: tags differ |

## Verification
All-zero operands isolate the substitution of zero and the identity of mixing a constant column. A published first-round vector pins down the byte order, the direction of the row rotation and the mixing coefficients together. Single-bit flips at spread-out positions show which tag byte each input byte feeds and so expose any mistake in the rotation or the byte selection. A seeded random stream with gaps, mixed modes, reference tags that either equal the expected tag or differ from it in one bit, and inputs that change after acceptance separates compare errors, pipeline slips and misuse of idle-cycle inputs.

// File: rtl/itu_pkg.sv
package itu_pkg;
  localparam int BLK_W   = 128;
  localparam int TAG_W   = 32;
  localparam int NCOL    = 4;
  localparam int NROW    = 4;
  localparam int NBYTE   = BLK_W / 8;

  typedef logic [BLK_W-1:0] blk_t;
  typedef logic [TAG_W-1:0] tag_t;

  // multiply by x in GF(2^8), polynomial 0x11B
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = gf_x2(aa);
    end
    return acc;
  endfunction

  // inverse as a^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    r    = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] b);
    logic [7:0] inv;
    logic [7:0] rot;
    logic [7:0] s;
    inv = gf_inv(b);
    rot = inv;
    s   = inv ^ 8'h63;
    for (int k = 0; k < 4; k++) begin
      rot = {rot[6:0], rot[7]};
      s   = s ^ rot;
    end
    return s;
  endfunction

  function automatic logic [7:0] byte_of(input blk_t v, input int idx);
    return v[BLK_W-1-8*idx -: 8];
  endfunction
endpackage

// File: rtl/itu_sub_shift.sv
module itu_sub_shift
  import itu_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] rkey,
  output logic [BLK_W-1:0] dout
);
  logic [BLK_W-1:0] keyed;
  assign keyed = din ^ rkey;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    localparam int ROW = g % NROW;
    localparam int COL = g / NROW;
    localparam int SRC = ((COL + ROW) % NCOL) * NROW + ROW;
    assign dout[BLK_W-1-8*g -: 8] = sub_byte(keyed[BLK_W-1-8*SRC -: 8]);
  end
endmodule

// File: rtl/itu_mix_key.sv
module itu_mix_key
  import itu_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] rkey,
  output logic [BLK_W-1:0] dout
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int TOP = BLK_W - 1 - 32*c;
    logic [7:0] a0, a1, a2, a3;
    logic [31:0] mixed;
    assign a0 = din[TOP      -: 8];
    assign a1 = din[TOP - 8  -: 8];
    assign a2 = din[TOP - 16 -: 8];
    assign a3 = din[TOP - 24 -: 8];
    always_comb begin
      mixed[31:24] = gf_mul(a0, 8'h02) ^ gf_mul(a1, 8'h03) ^ a2 ^ a3;
      mixed[23:16] = a0 ^ gf_mul(a1, 8'h02) ^ gf_mul(a2, 8'h03) ^ a3;
      mixed[15:8]  = a0 ^ a1 ^ gf_mul(a2, 8'h02) ^ gf_mul(a3, 8'h03);
      mixed[7:0]   = gf_mul(a0, 8'h03) ^ a1 ^ a2 ^ gf_mul(a3, 8'h02);
    end
    assign dout[TOP -: 32] = mixed ^ rkey[TOP -: 32];
  end
endmodule

// File: rtl/itu_tag_sel.sv
module itu_tag_sel
  import itu_pkg::*;
#(
  parameter int TAG_ROW = 0
) (
  input  logic [BLK_W-1:0] rnd,
  input  logic [TAG_W-1:0] ref_tag,
  input  logic             chk,
  output logic [TAG_W-1:0] tag,
  output logic             match,
  output logic             fail
);
  localparam int BPC = TAG_W / NCOL;

  for (genvar c = 0; c < NCOL; c++) begin : g_pick
    assign tag[TAG_W-1-BPC*c -: BPC] = rnd[BLK_W-1-32*c-8*TAG_ROW -: BPC];
  end

  logic same;
  assign same  = (tag == ref_tag);
  assign match = chk & same;
  assign fail  = chk & ~same;
endmodule

// File: rtl/itu_tag_unit.sv
module itu_tag_unit
  import itu_pkg::*;
#(
  parameter int TAG_ROW = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  input  logic [127:0] in_rkey0,
  input  logic [127:0] in_rkey1,
  input  logic         in_check,
  input  logic [31:0]  in_ref_tag,
  output logic         out_valid,
  output logic [31:0]  out_tag,
  output logic         out_match,
  output logic         out_fail
);
  // named events for the checks
  logic accept;
  assign accept = in_valid & in_ready;

  // stage 1: key 0, substitution, row rotation
  logic [BLK_W-1:0] s1_comb;
  itu_sub_shift u_sub (.din(in_data), .rkey(in_rkey0), .dout(s1_comb));

  logic             s1_vld;
  logic [BLK_W-1:0] s1_state;
  logic [BLK_W-1:0] s1_rkey1;
  logic             s1_chk;
  logic [TAG_W-1:0] s1_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      s1_vld   <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      s1_vld   <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_state <= s1_comb;
      s1_rkey1 <= in_rkey1;
      s1_chk   <= in_check;
      s1_ref   <= in_ref_tag;
    end
  end

  // stage 2: column mixing, key 1, tag selection and compare
  logic [BLK_W-1:0] s2_round;
  itu_mix_key u_mix (.din(s1_state), .rkey(s1_rkey1), .dout(s2_round));

  logic [TAG_W-1:0] s2_tag;
  logic             s2_match;
  logic             s2_fail;
  itu_tag_sel #(.TAG_ROW(TAG_ROW)) u_sel (
    .rnd(s2_round), .ref_tag(s1_ref), .chk(s1_chk),
    .tag(s2_tag), .match(s2_match), .fail(s2_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_match <= 1'b0;
      out_fail  <= 1'b0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_tag   <= s2_tag;
        out_match <= s2_match;
        out_fail  <= s2_fail;
      end
    end
  end

  // R1: ready comes up one cycle after reset release
  a_r1_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  // R2 and R7: a result exactly two edges after each acceptance and never otherwise
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(accept, 2));

  // R5: generate mode raises no verdict
  a_r5_gen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(in_check, 2)) |-> (!out_match && !out_fail));

  // R6 and R9: verdict follows the reference captured at acceptance
  a_r6_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_check, 2)) |-> (out_match == (out_tag == $past(in_ref_tag, 2))));

  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_check, 2)) |-> (out_match != out_fail));

  // R7: output held while idle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(!out_valid)) |-> $stable(out_tag));
endmodule

// File: tb/tb_itu_tag_unit.sv
module tb_itu_tag_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_data, in_rkey0, in_rkey1;
  logic         in_check;
  logic [31:0]  in_ref_tag;
  logic         out_valid;
  logic [31:0]  out_tag;
  logic         out_match, out_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  itu_tag_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rkey0(in_rkey0), .in_rkey1(in_rkey1),
    .in_check(in_check), .in_ref_tag(in_ref_tag), .out_valid(out_valid),
    .out_tag(out_tag), .out_match(out_match), .out_fail(out_fail)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sb [256];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // substitution table from generator walk (3 and its inverse)
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    for (int k = 0; k < 255; k++) begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rotl(q, 1) ^ rotl(q, 2) ^ rotl(q, 3) ^ rotl(q, 4);
      sb[p] = x ^ 8'h63;
    end
    sb[0] = 8'h63;
  endtask

  function automatic logic [7:0] dbl(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] bt(input logic [127:0] v, input int k);
    return v[127-8*k -: 8];
  endfunction

  // only the top row of each output column is needed for the tag
  function automatic logic [31:0] model_tag(input logic [127:0] d, input logic [127:0] k0,
                                            input logic [127:0] k1);
    logic [127:0] w;
    logic [7:0] a [4];
    logic [31:0] t;
    w = d ^ k0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) a[r] = sb[bt(w, ((c + r) % 4) * 4 + r)];
      t[31-8*c -: 8] = dbl(a[0]) ^ dbl(a[1]) ^ a[1] ^ a[2] ^ a[3] ^ bt(k1, 4*c);
    end
    return t;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // one isolated block; inputs scrambled after acceptance (R9, R7)
  task automatic run_one(input logic [127:0] d, input logic [127:0] k0, input logic [127:0] k1,
                         input logic chk, input logic [31:0] rt, output logic [31:0] tg,
                         output logic m, output logic f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_rkey0 = k0; in_rkey1 = k1;
    in_check = chk; in_ref_tag = rt;
    @(negedge clk);
    in_valid = 1'b0; in_data = rnd128(); in_check = ~chk; in_ref_tag = ~rt;
    check("R2 no early result", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    in_rkey0 = rnd128(); in_rkey1 = rnd128();
    check("R2 result after two edges", {127'd0, out_valid}, 128'd1);
    tg = out_tag; m = out_match; f = out_fail;
    @(negedge clk);
    check("R2 single pulse", {127'd0, out_valid}, 128'd0);
  endtask

  logic [31:0] tg, base;
  logic m, f;

  // stream history
  logic        h1_v, h2_v, h1_c, h2_c;
  logic [31:0] h1_t, h2_t, h1_r, h2_r;

  initial begin : main
    logic [127:0] d0, k0, k1;
    void'($urandom(32'd20240611));
    build_sbox();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_rkey0 = '0; in_rkey1 = '0;
    in_check = 1'b0; in_ref_tag = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {127'd0, out_valid}, 128'd0);
    check("R1 in_ready in reset", {127'd0, in_ready}, 128'd0);
    // idle inputs with valid low during reset and after
    in_data = rnd128();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 in_ready after reset", {127'd0, in_ready}, 128'd1);
    check("R7 idle gives no result", {127'd0, out_valid}, 128'd0);

    // R10 zero operands
    run_one('0, '0, '0, 1'b0, 32'h0, tg, m, f);
    check("R10 zero tag", {96'd0, tg}, {96'd0, 32'h63636363});
    check("R5 generate match low", {127'd0, m}, 128'd0);
    check("R5 generate fail low", {127'd0, f}, 128'd0);

    // R10 published first-round vector, in check mode with correct reference
    run_one(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            128'hd6aa74fdd2af72fadaa678f1d6ab76fe, 1'b1, 32'h89852dcb, tg, m, f);
    check("R10 known vector tag", {96'd0, tg}, {96'd0, 32'h89852dcb});
    check("R4 R3 model agrees", {96'd0, tg},
          {96'd0, model_tag(128'h00112233445566778899aabbccddeeff,
                            128'h000102030405060708090a0b0c0d0e0f,
                            128'hd6aa74fdd2af72fadaa678f1d6ab76fe)});
    check("R6 match on equal", {126'd0, m, f}, {126'd0, 2'b10});

    // R6 one-bit wrong reference
    run_one(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            128'hd6aa74fdd2af72fadaa678f1d6ab76fe, 1'b1, 32'h89852dca, tg, m, f);
    check("R6 fail on one-bit miss", {126'd0, m, f}, {126'd0, 2'b01});

    // R8 single-bit flips
    d0 = rnd128(); k0 = rnd128(); k1 = rnd128();
    run_one(d0, k0, k1, 1'b0, 32'h0, base, m, f);
    check("R3 random block", {96'd0, base}, {96'd0, model_tag(d0, k0, k1)});
    for (int p = 0; p < 128; p += 9) begin
      int idx, r, c, col;
      logic [31:0] diff, mask;
      idx = 15 - p / 8; r = idx % 4; c = idx / 4; col = (c - r + 4) % 4;
      mask = 32'hff000000 >> (8 * col);
      run_one(d0 ^ (128'd1 << p), k0, k1, 1'b0, 32'h0, tg, m, f);
      diff = tg ^ base;
      check("R8 other bytes unchanged", {96'd0, diff & ~mask}, 128'd0);
      check("R8 target byte changed", {127'd0, (diff & mask) != 0}, 128'd1);
    end

    // random stream with gaps
    h1_v = 0; h2_v = 0; h1_c = 0; h2_c = 0; h1_t = 0; h2_t = 0; h1_r = 0; h2_r = 0;
    for (int n = 0; n < 600; n++) begin
      logic v, c;
      logic [31:0] e, rt;
      @(negedge clk);
      check("R2 R7 stream valid", {127'd0, out_valid}, {127'd0, h2_v});
      if (h2_v) begin
        check("R3 R4 stream tag", {96'd0, out_tag}, {96'd0, h2_t});
        check("R5 R6 R9 stream verdict", {126'd0, out_match, out_fail},
              {126'd0, h2_c && (h2_t == h2_r), h2_c && (h2_t != h2_r)});
      end
      h2_v = h1_v; h2_c = h1_c; h2_t = h1_t; h2_r = h1_r;
      v = ($urandom % 4) != 0;
      c = $urandom % 2;
      in_data = rnd128(); in_rkey0 = rnd128(); in_rkey1 = rnd128();
      e = model_tag(in_data, in_rkey0, in_rkey1);
      case ($urandom % 3)
        0: rt = e;
        1: rt = e ^ (32'd1 << ($urandom % 32));
        default: rt = $urandom;
      endcase
      in_valid = v; in_check = c; in_ref_tag = rt;
      h1_v = v; h1_c = c; h1_t = e; h1_r = rt;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 drained", {127'd0, out_valid}, 128'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule